// File: doc/BRIEF.md
# DRAM Strobe Command Classifier

This block watches the four active-low control strobes of an asynchronous DRAM interface: row strobe, column strobe, write enable and output enable. It samples them with the system clock and works out which operation the controller is running from the order in which the strobes change, not from a snapshot of their levels. Each recognised operation is reported as a 4-bit code with a one-cycle valid pulse. Orderings that match no known operation raise a one-cycle error pulse. The block can serve as a passive bus analyser or as an on-chip checker for a DRAM controller.

The strobes pass through a synchroniser of `SYNC_STAGES` flops, two by default. Edges are taken from the synchronised copies. The clock must sample at least four times faster than the fastest strobe, and each strobe level must be held for at least two clock periods. The classifier is a state machine with these states:
- `ST_IDLE`: both row and column strobes high.
- `ST_ROW`: row open, column strobe high.
- `ST_ACC`: column access in progress.
- `ST_HIDE`: row strobe released while the column strobe is still held after an access.
- `ST_CBRP`: column strobe low with the row strobe high.
- `ST_REFL`: refresh row, column strobe low.
- `ST_REFH`: refresh row, column strobe released.
- `ST_ERR`: waits until both strobes are high.

Operation codes: 0 standby, 1 read, 2 early write, 3 delayed write, 4 read-modify-write, 5 page-mode cycle, 6 row-only refresh, 7 column-before-row refresh, 8 hidden refresh, 9 test-mode entry.

Top module: `dram_cmd_classifier`

## Requirements
- R1: When an access, page sequence or refresh ends with both row and column strobes high, a standby code 0 is reported, at the last of the two strobes to rise (the `ST_ROW`, `ST_ACC`, `ST_HIDE`, `ST_CBRP`, `ST_REFL` and `ST_REFH` to `ST_IDLE` transitions). The one exception is a row-only refresh, which reports R6 instead.
- R2: The first column strobe fall in an open row (`ST_ROW` to `ST_ACC`) reports code 2 if write enable is low at that moment, and code 1 if it is high.
- R3: During a read access, a write-enable fall with output enable high, where output enable has not been low during that access, reports delayed write code 3.
- R4: During a read access, a write-enable fall with output enable high, where output enable was low earlier in the same access, reports read-modify-write code 4.
- R5: Each further column strobe fall while the row strobe stays low after a first access reports page code 5.
- R6: A row strobe pulse with the column strobe high for its whole low time reports code 6 when the row strobe rises.
- R7: A column strobe fall with the row strobe high (`ST_IDLE` to `ST_CBRP`), followed by a row strobe fall, reports code 7 if write enable is high and code 9 if it is low. The report is made at the row strobe fall.
- R8: After an access, if the row strobe rises and falls again while the column strobe stays low (`ST_ACC` to `ST_HIDE` to `ST_REFL`), code 8 is reported at the second row fall.
- R9: The error output pulses, and the classifier stays silent until both strobes are high, in each of these cases:
  - row and column strobes fall in the same sample from `ST_IDLE`;
  - the column strobe falls again inside a refresh row (`ST_REFH`);
  - write enable falls during an access while output enable is low;
  - a row-edge and column-edge pair that cannot be ordered appears in `ST_ROW`, `ST_HIDE`, `ST_CBRP` or `ST_REFH`.
- R10: A report appears exactly three clock edges after the strobe change that causes it (with two synchroniser stages) and lasts one cycle. Valid and error are never high together.
- R11: During and right after reset, valid and error are low and the code reads 0. The code holds its last value between reports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strb_ras_n | input | 1 | Row strobe, active low, asynchronous |
| strb_cas_n | input | 1 | Column strobe, active low, asynchronous |
| strb_we_n | input | 1 | Write enable, active low, asynchronous |
| strb_oe_n | input | 1 | Output enable, active low, asynchronous |
| op_valid | output | 1 | One-cycle pulse marking a new operation code |
| op_code | output | 4 | Operation code, held between reports |
| op_err | output | 1 | One-cycle pulse on an illegal strobe ordering |

## Verification
The row and column strobe releases can fall in the same sample at the end of an access. The classifier must then report one standby and must not mistake the pair for the start of a hidden refresh. The bench provokes this by driving both strobes high on the same clock edge at the end of randomly chosen reads, and judges it by the exact sequence of reported codes, which must be read then standby. Simultaneous falls of both strobes from idle are driven the same way and must yield a single error pulse and nothing else.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
    localparam int OP_W    = 4;
    localparam int STROBES = 4;
    localparam int IX_RAS  = 0;
    localparam int IX_CAS  = 1;
    localparam int IX_WE   = 2;
    localparam int IX_OE   = 3;

    localparam logic [OP_W-1:0] OP_STANDBY = 4'd0;
    localparam logic [OP_W-1:0] OP_READ    = 4'd1;
    localparam logic [OP_W-1:0] OP_EWRITE  = 4'd2;
    localparam logic [OP_W-1:0] OP_DWRITE  = 4'd3;
    localparam logic [OP_W-1:0] OP_RMW     = 4'd4;
    localparam logic [OP_W-1:0] OP_PAGE    = 4'd5;
    localparam logic [OP_W-1:0] OP_ROWREF  = 4'd6;
    localparam logic [OP_W-1:0] OP_CBR     = 4'd7;
    localparam logic [OP_W-1:0] OP_HIDDEN  = 4'd8;
    localparam logic [OP_W-1:0] OP_TEST    = 4'd9;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ROW, ST_ACC, ST_HIDE, ST_CBRP, ST_REFL, ST_REFH, ST_ERR
    } cls_state_e;
endpackage

// File: rtl/dcc_sync.sv
module dcc_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2   // must be 2 or more
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], async_i[b]};
        end
        assign sync_o[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/dcc_edge.sv
module dcc_edge #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] fall_o,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= lvl_i;
    end

    assign fall_o = prev_q & ~lvl_i;
    assign rise_o = ~prev_q & lvl_i;
endmodule

// File: rtl/dcc_fsm.sv
module dcc_fsm
    import dcc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STROBES-1:0]  lvl_i,
    input  logic [STROBES-1:0]  fall_i,
    input  logic [STROBES-1:0]  rise_i,
    output logic                op_valid,
    output logic [OP_W-1:0]     op_code,
    output logic                op_err
);
    cls_state_e state_q, state_d;
    logic served_q, served_d;
    logic oe_low_q, oe_low_d;
    logic wr_done_q, wr_done_d;
    logic emit, err_d;
    logic [OP_W-1:0] code_d;
    logic valid_q, err_q;
    logic [OP_W-1:0] code_q;

    logic ras_l, cas_l, we_l, oe_l;
    logic ras_f, ras_r, cas_f, cas_r, we_f;
    logic unused_edges;

    assign ras_l = lvl_i[IX_RAS];
    assign cas_l = lvl_i[IX_CAS];
    assign we_l  = lvl_i[IX_WE];
    assign oe_l  = lvl_i[IX_OE];
    assign ras_f = fall_i[IX_RAS];
    assign ras_r = rise_i[IX_RAS];
    assign cas_f = fall_i[IX_CAS];
    assign cas_r = rise_i[IX_CAS];
    assign we_f  = fall_i[IX_WE];
    assign unused_edges = ^{fall_i[IX_OE], rise_i[IX_WE], rise_i[IX_OE]};

    // state and flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            served_q  <= 1'b0;
            oe_low_q  <= 1'b0;
            wr_done_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            served_q  <= served_d;
            oe_low_q  <= oe_low_d;
            wr_done_q <= wr_done_d;
        end
    end

    // next state and report decode
    always_comb begin
        state_d   = state_q;
        served_d  = served_q;
        oe_low_d  = oe_low_q | ((state_q == ST_ACC) & ~oe_l);
        wr_done_d = wr_done_q;
        emit      = 1'b0;
        err_d     = 1'b0;
        code_d    = OP_STANDBY;
        unique case (state_q)
            ST_IDLE: begin
                if (ras_f && cas_f) begin
                    err_d = 1'b1; state_d = ST_ERR;
                end else if (ras_f) begin
                    state_d = ST_ROW; served_d = 1'b0;
                end else if (cas_f) begin
                    state_d = ST_CBRP;
                end
            end
            ST_ROW: begin
                if (cas_f && ras_r) begin
                    err_d = 1'b1; state_d = ST_ERR;
                end else if (ras_r) begin
                    emit = 1'b1; state_d = ST_IDLE;
                    code_d = served_q ? OP_STANDBY : OP_ROWREF;
                end else if (cas_f) begin
                    emit = 1'b1; state_d = ST_ACC;
                    code_d = served_q ? OP_PAGE : (we_l ? OP_READ : OP_EWRITE);
                    served_d  = 1'b1;
                    oe_low_d  = ~oe_l;
                    wr_done_d = ~we_l;
                end
            end
            ST_ACC: begin
                if (ras_r && cas_r) begin
                    emit = 1'b1; state_d = ST_IDLE;
                end else if (ras_r) begin
                    state_d = ST_HIDE;
                end else if (cas_r) begin
                    state_d = ST_ROW;
                end else if (we_f && !wr_done_q) begin
                    wr_done_d = 1'b1;
                    if (!oe_l) begin
                        err_d = 1'b1; state_d = ST_ERR;
                    end else begin
                        emit = 1'b1;
                        code_d = oe_low_q ? OP_RMW : OP_DWRITE;
                    end
                end
            end
            ST_HIDE: begin
                if (ras_f && cas_r) begin
                    err_d = 1'b1; state_d = ST_ERR;
                end else if (ras_f) begin
                    emit = 1'b1; code_d = OP_HIDDEN; state_d = ST_REFL;
                end else if (cas_r) begin
                    emit = 1'b1; state_d = ST_IDLE;
                end
            end
            ST_CBRP: begin
                if (ras_f && cas_r) begin
                    err_d = 1'b1; state_d = ST_ERR;
                end else if (ras_f) begin
                    emit = 1'b1; state_d = ST_REFL;
                    code_d = we_l ? OP_CBR : OP_TEST;
                end else if (cas_r) begin
                    emit = 1'b1; state_d = ST_IDLE;
                end
            end
            ST_REFL: begin
                if (ras_r) begin
                    if (cas_l) begin
                        emit = 1'b1; state_d = ST_IDLE;
                    end else begin
                        state_d = ST_CBRP;
                    end
                end else if (cas_r) begin
                    state_d = ST_REFH;
                end
            end
            ST_REFH: begin
                if (cas_f) begin
                    err_d = 1'b1; state_d = ST_ERR;
                end else if (ras_r) begin
                    emit = 1'b1; state_d = ST_IDLE;
                end
            end
            ST_ERR: begin
                if (ras_l && cas_l) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            code_q  <= OP_STANDBY;
        end else begin
            valid_q <= emit;
            err_q   <= err_d;
            if (emit) code_q <= code_d;
        end
    end

    assign op_valid = valid_q;
    assign op_code  = code_q;
    assign op_err   = err_q;

    assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && op_err));
    assert_access_we_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_EWRITE) && $past(state_q) == ST_ROW) |-> !$past(we_l));
    assert_rowref_cas_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_ROWREF) |-> $past(cas_l));
    assert_cbr_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_CBR) |-> $past(we_l));
    assert_test_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_TEST) |-> !$past(we_l));
    assert_hidden_cas_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_HIDDEN) |-> !$past(cas_l));
endmodule

// File: rtl/dram_cmd_classifier.sv
module dram_cmd_classifier
    import dcc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strb_ras_n,
    input  logic            strb_cas_n,
    input  logic            strb_we_n,
    input  logic            strb_oe_n,
    output logic            op_valid,
    output logic [OP_W-1:0] op_code,
    output logic            op_err
);
    logic [STROBES-1:0] raw, lvl, fall, rise;

    assign raw[IX_RAS] = strb_ras_n;
    assign raw[IX_CAS] = strb_cas_n;
    assign raw[IX_WE]  = strb_we_n;
    assign raw[IX_OE]  = strb_oe_n;

    dcc_sync #(.W(STROBES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw), .sync_o(lvl)
    );

    dcc_edge #(.W(STROBES)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .fall_o(fall), .rise_o(rise)
    );

    dcc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .fall_i(fall), .rise_i(rise),
        .op_valid(op_valid), .op_code(op_code), .op_err(op_err)
    );
endmodule

// File: tb/dram_cmd_classifier_tb.sv
`timescale 1ns/1ps
module dram_cmd_classifier_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras = 1'b1, cas = 1'b1, we = 1'b1, oe = 1'b1;
    logic op_valid, op_err;
    logic [3:0] op_code;

    int checks = 0;
    int fails  = 0;
    int log_n  = 0;
    logic [3:0] log_c [0:1023];
    int base = 0;
    int exp_n = 0;
    logic [3:0] exp_c [0:31];

    localparam logic [3:0] ERR_TAG = 4'd15;

    always #10 clk = ~clk;

    dram_cmd_classifier u_dut (
        .clk(clk), .rst_n(rst_n),
        .strb_ras_n(ras), .strb_cas_n(cas), .strb_we_n(we), .strb_oe_n(oe),
        .op_valid(op_valid), .op_code(op_code), .op_err(op_err)
    );

    always @(negedge clk) begin
        if (rst_n && (op_valid || op_err) && log_n < 1024) begin
            log_c[log_n] <= op_err ? ERR_TAG : op_code;
            log_n <= log_n + 1;
        end
    end

    function automatic logic [3:0] refresh_code(input bit test_mode);
        return test_mode ? 4'd9 : 4'd7;
    endfunction

    function automatic logic [3:0] first_access_code(input bit wr);
        return wr ? 4'd2 : 4'd1;
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic gap();
        step($urandom_range(2, 4));
    endtask

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic op_begin();
        base = log_n;
        exp_n = 0;
    endtask

    task automatic push(input logic [3:0] c);
        exp_c[exp_n] = c;
        exp_n++;
    endtask

    task automatic op_end(input string req);
        int got;
        int bad;
        step(8);
        got = log_n - base;
        bad = -1;
        if (got == exp_n) begin
            for (int i = 0; i < exp_n; i++)
                if (bad < 0 && log_c[base + i] !== exp_c[i]) bad = i;
        end
        if (got != exp_n) check(1'b0, {req, " report count"}, got, exp_n);
        else if (bad >= 0) check(1'b0, {req, " report code"}, int'(log_c[base + bad]), int'(exp_c[bad]));
        else check(1'b1, req, 0, 0);
    endtask

    task automatic op_read(input bit sim_end);
        op_begin();
        ras = 0; gap(); cas = 0; push(first_access_code(0)); gap();
        oe = 0; gap(); oe = 1; gap();
        if (sim_end) begin ras = 1; cas = 1; end
        else begin cas = 1; gap(); ras = 1; end
        push(4'd0); gap();
        op_end(sim_end ? "R2 R1 simultaneous release" : "R2 R1 read");
    endtask

    task automatic op_early();
        op_begin();
        we = 0; gap(); ras = 0; gap(); cas = 0; push(first_access_code(1)); gap();
        cas = 1; gap(); ras = 1; push(4'd0); gap(); we = 1; gap();
        op_end("R2 early write");
    endtask

    task automatic op_delayed();
        op_begin();
        ras = 0; gap(); cas = 0; push(4'd1); gap();
        we = 0; push(4'd3); gap(); cas = 1; gap(); we = 1; gap();
        ras = 1; push(4'd0); gap();
        op_end("R3 delayed write");
    endtask

    task automatic op_rmw();
        op_begin();
        ras = 0; gap(); cas = 0; push(4'd1); gap();
        oe = 0; gap(); oe = 1; gap(); we = 0; push(4'd4); gap();
        cas = 1; we = 1; gap(); ras = 1; push(4'd0); gap();
        op_end("R4 read-modify-write");
    endtask

    task automatic op_page(input int n, input bit wr);
        op_begin();
        we = wr ? 1'b0 : 1'b1; gap();
        ras = 0; gap(); cas = 0; push(first_access_code(wr)); gap(); cas = 1;
        for (int i = 0; i < n; i++) begin
            gap(); cas = 0; push(4'd5); gap(); cas = 1;
        end
        gap(); ras = 1; push(4'd0); gap(); we = 1; gap();
        op_end("R5 page cycles");
    endtask

    task automatic op_rowref();
        op_begin();
        ras = 0; gap(); ras = 1; push(4'd6); gap();
        op_end("R6 row-only refresh");
    endtask

    task automatic op_cbr(input bit test_mode, input bit ras_first);
        op_begin();
        if (test_mode) begin we = 0; gap(); end
        cas = 0; gap(); ras = 0; push(refresh_code(test_mode)); gap();
        if (ras_first) begin ras = 1; gap(); cas = 1; end
        else begin cas = 1; gap(); ras = 1; end
        push(4'd0); gap(); we = 1; gap();
        op_end(test_mode ? "R7 test entry" : "R7 column-first refresh");
    endtask

    task automatic op_hidden();
        op_begin();
        ras = 0; gap(); cas = 0; push(4'd1); gap(); oe = 0; gap();
        ras = 1; gap(); ras = 0; push(4'd8); gap(); ras = 1; gap();
        cas = 1; push(4'd0); gap(); oe = 1; gap();
        op_end("R8 hidden refresh");
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        step(3);
        // R11: reset state
        check(op_valid === 1'b0 && op_err === 1'b0 && op_code === 4'd0,
              "R11 reset outputs", {op_valid, op_err, op_code}, 0);
        rst_n = 1'b1;
        step(4);
        check(op_valid === 1'b0 && op_err === 1'b0 && op_code === 4'd0,
              "R11 after reset", {op_valid, op_err, op_code}, 0);

        // R10: exact latency and single-cycle pulse
        ras = 0; step(4);
        ras = 1;
        step(1); check(op_valid === 1'b0, "R10 edge+1", op_valid, 0);
        step(1); check(op_valid === 1'b0, "R10 edge+2", op_valid, 0);
        step(1); check(op_valid === 1'b1 && op_code === 4'd6, "R10 edge+3", {op_valid, op_code}, 22);
        step(1); check(op_valid === 1'b0 && op_code === 4'd6, "R10 pulse ends, R11 code held", {op_valid, op_code}, 6);
        step(6);

        // directed corner cases
        op_read(1'b0);
        op_read(1'b1);
        op_early();
        op_delayed();
        op_rmw();
        op_page(3, 1'b0);
        op_page(2, 1'b1);
        op_rowref();
        op_cbr(1'b0, 1'b1);
        op_cbr(1'b0, 1'b0);
        op_cbr(1'b1, 1'b0);
        op_hidden();

        // R9: column strobe falls again inside a refresh row
        op_begin();
        cas = 0; gap(); ras = 0; push(4'd7); gap(); cas = 1; gap();
        cas = 0; push(ERR_TAG); gap(); cas = 1; gap(); ras = 1; gap();
        op_end("R9 column fall in refresh row");
        // R9: write-enable fall with output enable low
        op_begin();
        ras = 0; gap(); cas = 0; push(4'd1); gap(); oe = 0; gap();
        we = 0; push(ERR_TAG); gap(); we = 1; cas = 1; oe = 1; gap(); ras = 1; gap();
        op_end("R9 write with output enabled");
        // R9: both strobes fall in one sample
        op_begin();
        ras = 0; cas = 0; push(ERR_TAG); gap(); ras = 1; cas = 1; gap();
        op_end("R9 simultaneous fall");
        op_read(1'b0);

        // constrained random operation mix
        for (int k = 0; k < 40; k++) begin
            int kind;
            kind = $urandom_range(0, 8);
            case (kind)
                0: op_read($urandom_range(0, 1) == 1);
                1: op_early();
                2: op_delayed();
                3: op_rmw();
                4: op_page($urandom_range(1, 3), $urandom_range(0, 1) == 1);
                5: op_rowref();
                6: op_cbr(1'b0, $urandom_range(0, 1) == 1);
                7: op_cbr(1'b1, $urandom_range(0, 1) == 1);
                default: op_hidden();
            endcase
        end

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule